// File: doc/BRIEF.md
# Compare-Match Timer with PWM Output

This block is an up-counter that advances one step for each pulse on a slow-clock enable input while a run bit is set. When the count reaches the value in a period register, the count wraps to zero on that enable pulse. A full cycle therefore lasts the period value plus one enable pulses. The same event can latch an interrupt flag, which drives a level interrupt request. A second register holds a duty value. A single PWM output goes high after the enable pulse on which the count equals the duty value. It goes low after the enable pulse on which the count equals the period value. If both happen on the same count, the output goes low.

Software reaches the block through a plain register port. A write takes effect on the clock edge where write enable is high. Read data is combinational from the address. The register at address 0 is the control register. The interrupt flag is cleared by writing one to it. A clear bit in the control register zeroes the count and drives the output low without stopping the timer.

Top module: `cmt_timer`

## Requirements
- R1: After reset the count is 0, the period register is 0xFF, the duty register is 0x00, the control register reads 0, the flag reads 0, and both `pwm_out` and `irq` are low.
- R2: On each clock where `tick` is 1 and run is set, the count rises by one. If the count equals the period register on that clock, it becomes 0 instead, so one cycle is period+1 ticks long.
- R3: On a clock where `tick` is 0 or run is clear, the count and `pwm_out` keep their values.
- R4: After a counting tick on which the count equals the duty register and not the period register, `pwm_out` is 1. The output is high for period−duty ticks of each cycle when duty < period, and never when duty > period.
- R5: After a counting tick on which the count equals the period register, `pwm_out` is 0, even when the duty register holds the same value.
- R6: A counting tick with count equal to period sets the flag only when the interrupt enable bit is 1.
- R7: Writing address 3 with bit 0 = 1 clears the flag. Writing it with bit 0 = 0 leaves the flag unchanged.
- R8: If a flag set and a write-one-to-clear fall on the same clock, the flag ends up set.
- R9: `irq` equals the flag. It stays high across further matches and drops only when software clears the flag.
- R10: Writing the duty register, with or without a tick on the same clock, never changes the count or its sequence.
- R11: Writing the control register with bit 1 = 1 sets the count to 0 and `pwm_out` to 0. A tick on that same clock is ignored, and the bit always reads back 0.
- R12: Register map. Address 0 is control: bit 0 is run, bit 1 is counter clear, and bit 2 is interrupt enable. Address 1 is period, address 2 is duty, address 3 bit 0 is the flag, and address 4 is the count (read-only). Every other address reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Slow-clock enable, one clock wide per count step |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address |
| wr_data | input | 8 | Register write data |
| rd_data | output | 8 | Register read data for `addr` |
| irq | output | 1 | Level interrupt request, equal to the flag |
| pwm_out | output | 1 | PWM waveform |

## Verification
The bench walks several period/duty pairs and counts the high ticks of one whole cycle. The pairs include duty equal to period, duty above period, duty zero and period zero. A design with the edge order swapped, or one that let the rise win a tie, would give the wrong high count. Directed tests write a zero to the flag, which a design decoding the write as a plain store would wrongly clear. They put a match and a clear on the same clock, which a clear-priority flag would lose. They write duty and the clear bit together with a tick, which would expose any path from duty to the counter or a clear that loses to counting. They also check that the count and output hold while stopped, and that period zero turns the timer into a one-tick wrap.

// File: rtl/cmt_pkg.sv
package cmt_pkg;

    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        REG_CTRL   = 3'd0,
        REG_PERIOD = 3'd1,
        REG_DUTY   = 3'd2,
        REG_FLAG   = 3'd3,
        REG_COUNT  = 3'd4
    } reg_addr_e;

    localparam int CTRL_RUN_BIT = 0;
    localparam int CTRL_CLR_BIT = 1;
    localparam int CTRL_IE_BIT  = 2;
    localparam int FLAG_BIT     = 0;

    typedef struct packed {
        logic ie;
        logic run;
    } ctrl_t;

    typedef struct packed {
        logic step;
        logic cmp;
        logic duty;
    } match_t;

    // Falling (period) action outranks rising (duty) action.
    function automatic logic pwm_next(input logic cur, input match_t m);
        logic nxt;
        nxt = cur;
        if (m.step) begin
            if (m.cmp)
                nxt = 1'b0;
            else if (m.duty)
                nxt = 1'b1;
        end
        return nxt;
    endfunction

endpackage

// File: rtl/cmt_regs.sv
module cmt_regs
    import cmt_pkg::*;
#(
    parameter int         W          = 8,
    parameter logic [W-1:0] PERIOD_RST = '1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [W-1:0]      wr_data,
    input  logic [W-1:0]      cnt,
    input  logic              flag,
    output ctrl_t             ctrl,
    output logic [W-1:0]      period,
    output logic [W-1:0]      duty,
    output logic              clr_pulse,
    output logic              flag_w1c,
    output logic [W-1:0]      rd_data
);

    logic wr_ctrl, wr_period, wr_duty;

    always_comb begin
        wr_ctrl   = wr_en && (addr == REG_CTRL);
        wr_period = wr_en && (addr == REG_PERIOD);
        wr_duty   = wr_en && (addr == REG_DUTY);
        clr_pulse = wr_ctrl && wr_data[CTRL_CLR_BIT];
        flag_w1c  = wr_en && (addr == REG_FLAG) && wr_data[FLAG_BIT];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl   <= '0;
            period <= PERIOD_RST;
            duty   <= '0;
        end else begin
            if (wr_ctrl) begin
                ctrl.run <= wr_data[CTRL_RUN_BIT];
                ctrl.ie  <= wr_data[CTRL_IE_BIT];
            end
            if (wr_period)
                period <= wr_data;
            if (wr_duty)
                duty <= wr_data;
        end
    end

    always_comb begin
        rd_data = '0;
        case (addr)
            REG_CTRL: begin
                rd_data[CTRL_RUN_BIT] = ctrl.run;
                rd_data[CTRL_IE_BIT]  = ctrl.ie;
            end
            REG_PERIOD: rd_data = period;
            REG_DUTY:   rd_data = duty;
            REG_FLAG:   rd_data[FLAG_BIT] = flag;
            REG_COUNT:  rd_data = cnt;
            default:    rd_data = '0;
        endcase
    end

    AST_DUTY_ONLY_BY_WRITE: assert property (@(posedge clk) disable iff (rst)
        !wr_duty |=> $stable(duty)); // R10

    AST_PERIOD_ONLY_BY_WRITE: assert property (@(posedge clk) disable iff (rst)
        !wr_period |=> $stable(period)); // R12

endmodule

// File: rtl/cmt_counter.sv
module cmt_counter
    import cmt_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         step,
    input  logic         clr,
    input  logic [W-1:0] period,
    input  logic [W-1:0] duty,
    output logic [W-1:0] cnt,
    output match_t       match
);

    always_comb begin
        match.step = step;
        match.cmp  = step && (cnt == period);
        match.duty = step && (cnt == duty);
    end

    always_ff @(posedge clk) begin
        if (rst || clr)
            cnt <= '0;
        else if (match.cmp)
            cnt <= '0;
        else if (step)
            cnt <= cnt + 1'b1;
    end

    AST_CNT_WRAP: assert property (@(posedge clk) disable iff (rst)
        (step && !clr && cnt == period) |=> cnt == '0); // R2

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
        (step && !clr && cnt != period) |=> cnt == W'($past(cnt) + 1'b1)); // R2

    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!step && !clr) |=> $stable(cnt)); // R3

endmodule

// File: rtl/cmt_pwm.sv
module cmt_pwm
    import cmt_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   clr,
    input  match_t match,
    output logic   pwm
);

    always_ff @(posedge clk) begin
        if (rst || clr)
            pwm <= 1'b0;
        else
            pwm <= pwm_next(pwm, match);
    end

    AST_PWM_RISE: assert property (@(posedge clk) disable iff (rst)
        (match.duty && !match.cmp && !clr) |=> pwm); // R4

    AST_PWM_FALL: assert property (@(posedge clk) disable iff (rst)
        match.cmp |=> !pwm); // R5

    AST_PWM_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!match.step && !clr) |=> $stable(pwm)); // R3

endmodule

// File: rtl/cmt_flag.sv
module cmt_flag (
    input  logic clk,
    input  logic rst,
    input  logic set,
    input  logic w1c,
    output logic flag
);

    always_ff @(posedge clk) begin
        if (rst)
            flag <= 1'b0;
        else if (set)
            flag <= 1'b1;
        else if (w1c)
            flag <= 1'b0;
    end

    AST_FLAG_SET_WINS: assert property (@(posedge clk) disable iff (rst)
        set |=> flag); // R8

    AST_FLAG_W1C: assert property (@(posedge clk) disable iff (rst)
        (w1c && !set) |=> !flag); // R7

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
        (flag && !w1c) |=> flag); // R9

endmodule

// File: rtl/cmt_timer.sv
module cmt_timer
    import cmt_pkg::*;
#(
    parameter int           W          = 8,
    parameter logic [W-1:0] PERIOD_RST = '1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [W-1:0]      wr_data,
    output logic [W-1:0]      rd_data,
    output logic              irq,
    output logic              pwm_out
);

    ctrl_t          ctrl;
    logic [W-1:0]   period, duty, cnt;
    logic           clr_pulse, flag_w1c, flag, step;
    match_t         match;

    // A clear write outranks a tick on the same clock.
    assign step = tick && ctrl.run && !clr_pulse;

    cmt_regs #(.W(W), .PERIOD_RST(PERIOD_RST)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .addr      (addr),
        .wr_data   (wr_data),
        .cnt       (cnt),
        .flag      (flag),
        .ctrl      (ctrl),
        .period    (period),
        .duty      (duty),
        .clr_pulse (clr_pulse),
        .flag_w1c  (flag_w1c),
        .rd_data   (rd_data)
    );

    cmt_counter #(.W(W)) u_counter (
        .clk    (clk),
        .rst    (rst),
        .step   (step),
        .clr    (clr_pulse),
        .period (period),
        .duty   (duty),
        .cnt    (cnt),
        .match  (match)
    );

    cmt_pwm u_pwm (
        .clk   (clk),
        .rst   (rst),
        .clr   (clr_pulse),
        .match (match),
        .pwm   (pwm_out)
    );

    cmt_flag u_flag (
        .clk  (clk),
        .rst  (rst),
        .set  (match.cmp && ctrl.ie),
        .w1c  (flag_w1c),
        .flag (flag)
    );

    assign irq = flag;

    AST_CLR_ZEROES: assert property (@(posedge clk) disable iff (rst)
        clr_pulse |=> (cnt == '0) && !pwm_out); // R11

    AST_NO_SET_WITHOUT_IE: assert property (@(posedge clk) disable iff (rst)
        (!flag && !ctrl.ie) |=> !irq); // R6

endmodule

// File: tb/cmt_timer_tb.sv
module cmt_timer_tb;

    logic       clk = 1'b0;
    logic       rst;
    logic       tick;
    logic       wr_en;
    logic [2:0] addr;
    logic [7:0] wr_data;
    logic [7:0] rd_data;
    logic       irq;
    logic       pwm_out;

    int total = 0;
    int bad   = 0;

    always #10 clk = ~clk;

    cmt_timer u_dut (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick),
        .wr_en   (wr_en),
        .addr    (addr),
        .wr_data (wr_data),
        .rd_data (rd_data),
        .irq     (irq),
        .pwm_out (pwm_out)
    );

    // {period, duty, expected high ticks over one cycle}
    localparam logic [23:0] VEC [8] = '{
        {8'd9,   8'd3,  8'd6},
        {8'd9,   8'd0,  8'd9},
        {8'd9,   8'd9,  8'd0},
        {8'd9,   8'd12, 8'd0},
        {8'd4,   8'd1,  8'd3},
        {8'd0,   8'd0,  8'd0},
        {8'd15,  8'd14, 8'd1},
        {8'd255, 8'd0,  8'd255}
    };

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wr_tick(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wr_data = d; wr_en = 1'b1; tick = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; tick = 1'b0;
    endtask

    task automatic tick_once();
        @(negedge clk);
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        addr = a; wr_en = 1'b0;
        #1 d = rd_data;
    endtask

    initial begin
        #3_000_000;
        bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [7:0] v;
        int         high;
        rst = 1'b1; tick = 1'b0; wr_en = 1'b0; addr = '0; wr_data = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state, R12 map
        rd(3'd4, v); check("R1 count", v, 0);
        rd(3'd1, v); check("R1 period", v, 8'hFF);
        rd(3'd2, v); check("R1 duty", v, 0);
        rd(3'd0, v); check("R1 ctrl", v, 0);
        rd(3'd3, v); check("R1 flag", v, 0);
        check("R1 pwm", pwm_out, 0);
        check("R1 irq", irq, 0);

        // Vector table: R4 R5 R2
        foreach (VEC[i]) begin
            wr(3'd1, VEC[i][23:16]);
            wr(3'd2, VEC[i][15:8]);
            wr(3'd0, 8'h03);
            high = 0;
            for (int t = 0; t <= int'(VEC[i][23:16]); t++) begin
                tick_once();
                if (pwm_out) high++;
            end
            check($sformatf("R4/R5 vec%0d high ticks", i), high, int'(VEC[i][7:0]));
            rd(3'd4, v); check($sformatf("R2 vec%0d wrap", i), v, 0);
            check($sformatf("R5 vec%0d low at wrap", i), pwm_out, 0);
        end

        // R2 step and R3 hold
        wr(3'd1, 8'hFF);
        wr(3'd2, 8'd2);
        wr(3'd0, 8'h03);
        repeat (5) tick_once();
        rd(3'd4, v); check("R2 step count", v, 5);
        check("R4 pwm high after duty", pwm_out, 1);
        repeat (4) @(negedge clk);
        rd(3'd4, v); check("R3 hold no tick", v, 5);
        wr(3'd0, 8'h00);
        repeat (3) tick_once();
        rd(3'd4, v); check("R3 hold stopped", v, 5);
        check("R3 pwm held", pwm_out, 1);

        // R10 duty write with tick
        wr(3'd0, 8'h01);
        wr_tick(3'd2, 8'h40);
        rd(3'd4, v); check("R10 count after duty write", v, 6);
        tick_once();
        rd(3'd4, v); check("R10 sequence kept", v, 7);

        // R11 clear with tick
        wr_tick(3'd0, 8'h03);
        rd(3'd4, v); check("R11 count cleared", v, 0);
        check("R11 pwm low", pwm_out, 0);
        rd(3'd0, v); check("R11 clear bit reads 0", v, 8'h01);
        rd(3'd5, v); check("R12 unmapped reads 0", v, 0);
        rd(3'd2, v); check("R12 duty readback", v, 8'h40);

        // R6 flag only with enable
        wr(3'd1, 8'd2);
        wr(3'd0, 8'h03);
        repeat (3) tick_once();
        rd(3'd3, v); check("R6 no flag when disabled", v, 0);
        wr(3'd0, 8'h05);
        repeat (3) tick_once();
        rd(3'd3, v); check("R6 flag set on match", v, 1);
        check("R9 irq follows flag", irq, 1);

        // R7 write zero ignored
        wr(3'd3, 8'h00);
        rd(3'd3, v); check("R7 write 0 ignored", v, 1);
        repeat (2) tick_once();
        check("R9 irq held", irq, 1);
        wr(3'd3, 8'h01);
        rd(3'd3, v); check("R7 write 1 clears", v, 0);
        check("R9 irq dropped", irq, 0);

        // R8 set beats clear (count is now 2 == period)
        rd(3'd4, v); check("R8 setup count", v, 2);
        wr_tick(3'd3, 8'h01);
        rd(3'd3, v); check("R8 set wins", v, 1);
        check("R8 irq", irq, 1);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule